// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block receives configuration words over a three-pin serial port (shift clock, data, load strobe) and stores them in four destination registers. Data bits enter a 24-bit shift register, most significant bit first, on each rising edge of the serial clock. A rising edge on the load strobe commits the word. The two least significant bits of that same word choose the destination register.

Destination code 00 goes to the reference-divider register, which holds a 14-bit value. Code 01 goes to the counter register, which holds a 6-bit A value and a 13-bit B value. Code 10 goes to the function register, which keeps 22 bits and does not interpret them. Code 11 is an initialization write. It loads the function register and also emits a single-cycle counter-reset pulse.

All three serial pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and its edges are detected in the system-clock domain. The serial clock must therefore be slower than the system clock, with each level held for at least two system-clock periods.

The block has no valid/ready stream interface. The serial port cannot be back-pressured, so the sender simply paces its bits. The register outputs are plain level signals that always show the last committed value.

Top module: `serial_cfg_loader`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register output and `cnt_rst_o` read zero until the first commit.
- R2: Bits are shifted in most significant first. After 24 rising serial-clock edges, the first bit sent sits at word bit 23 and the last at bit 0. Word bits [1:0] are the destination code.
- R3: With code 00, `ref_div_o` takes word bits [15:2]. The A, B and function values are unchanged.
- R4: With code 01, `a_cnt_o` takes word bits [7:2] and `b_cnt_o` takes bits [20:8]. The reference and function values are unchanged.
- R5: With code 10, `func_o` takes word bits [23:2] and `cnt_rst_o` stays low.
- R6: With code 11, `func_o` takes word bits [23:2] and `cnt_rst_o` is high for exactly one system-clock cycle.
- R7: When more than 24 bits are shifted before a strobe, only the last 24 are used.
- R8: Outputs change only on a commit. They update on the third system-clock rising edge after the strobe is first seen high. Shifting without a strobe changes no output.
- R9: A strobe held high for many cycles commits once and gives at most one counter-reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data (asynchronous) |
| ser_le_i | input | 1 | Load strobe (asynchronous) |
| ref_div_o | output | 14 | Reference-divider value |
| a_cnt_o | output | 6 | A counter value |
| b_cnt_o | output | 13 | B counter value |
| func_o | output | 22 | Function register contents |
| cnt_rst_o | output | 1 | One-cycle pulse marking an initialization write |

## Verification
A wrong shift-register bit or a wrong decode shows up in the wrong field, or in the wrong destination, on the third system-clock edge after the strobe. Because of this, the reference model is compared against every output on every cycle. If an edge detector is stuck, the fault appears either as a missing update or as an extra update during serial traffic without a strobe. It can also appear as repeated pulses while the strobe is held. Extra-long frames and strobes held for a long time are driven on purpose to expose faults in bit selection and in strobe handling.

// File: rtl/slc_pkg.sv
package slc_pkg;
  localparam int CODE_W = 2;
  typedef enum logic [CODE_W-1:0] {
    DST_REF  = 2'b00,
    DST_AB   = 2'b01,
    DST_FUNC = 2'b10,
    DST_INIT = 2'b11
  } dst_e;
endpackage

// File: rtl/slc_sync.sv
module slc_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/slc_shifter.sv
module slc_shifter #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               sdat_s,
  input  logic               sle_s,
  output logic [FRAME_W-1:0] word_o,
  output logic               commit_o
);
  logic sclk_q, sle_q;
  logic shift_en;

  assign shift_en = sclk_s & ~sclk_q;
  assign commit_o = sle_s & ~sle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sle_q  <= 1'b0;
      word_o <= '0;
    end else begin
      sclk_q <= sclk_s;
      sle_q  <= sle_s;
      if (shift_en) word_o <= {word_o[FRAME_W-2:0], sdat_s};
    end
  end

  // A held strobe yields a single commit
  assert_commit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);
  // The register only moves on a detected serial clock rise
  assert_shift_only_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_s && !sclk_q) |=> $stable(word_o));
endmodule

// File: rtl/slc_latches.sv
module slc_latches
  import slc_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int R_W     = 14,
  parameter int A_W     = 6,
  parameter int B_W     = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic [R_W-1:0]     ref_div_o,
  output logic [A_W-1:0]     a_cnt_o,
  output logic [B_W-1:0]     b_cnt_o,
  output logic [FRAME_W-CODE_W-1:0] func_o,
  output logic               cnt_rst_o
);
  localparam int A_LO = CODE_W;
  localparam int B_LO = A_LO + A_W;
  localparam int R_LO = CODE_W;
  localparam int F_W  = FRAME_W - CODE_W;

  dst_e code;
  logic ld_ref, ld_ab, ld_func, ld_init;

  assign code    = dst_e'(word_i[CODE_W-1:0]);
  assign ld_ref  = commit_i && (code == DST_REF);
  assign ld_ab   = commit_i && (code == DST_AB);
  assign ld_init = commit_i && (code == DST_INIT);
  assign ld_func = commit_i && ((code == DST_FUNC) || (code == DST_INIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_div_o <= '0;
      a_cnt_o   <= '0;
      b_cnt_o   <= '0;
      func_o    <= '0;
      cnt_rst_o <= 1'b0;
    end else begin
      cnt_rst_o <= ld_init;
      if (ld_ref)  ref_div_o <= word_i[R_LO +: R_W];
      if (ld_ab) begin
        a_cnt_o <= word_i[A_LO +: A_W];
        b_cnt_o <= word_i[B_LO +: B_W];
      end
      if (ld_func) func_o <= word_i[CODE_W +: F_W];
    end
  end

  assert_pulse_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst_o |=> !cnt_rst_o);
  assert_pulse_from_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst_o |-> $past(commit_i) && ($past(word_i[CODE_W-1:0]) == 2'b11));
  assert_ab_needs_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(a_cnt_o) && $stable(b_cnt_o));
  assert_ref_needs_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(ref_div_o) && $stable(func_o));
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int FRAME_W = 24,
  parameter int R_W     = 14,
  parameter int A_W     = 6,
  parameter int B_W     = 13,
  parameter int SYNC_N  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk_i,
  input  logic           ser_dat_i,
  input  logic           ser_le_i,
  output logic [R_W-1:0] ref_div_o,
  output logic [A_W-1:0] a_cnt_o,
  output logic [B_W-1:0] b_cnt_o,
  output logic [FRAME_W-3:0] func_o,
  output logic           cnt_rst_o
);
  logic [2:0]         pins_s;
  logic [FRAME_W-1:0] word;
  logic               commit;

  slc_sync #(.N(3), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ser_le_i, ser_dat_i, ser_clk_i}),
    .q_o   (pins_s)
  );

  slc_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (pins_s[0]),
    .sdat_s   (pins_s[1]),
    .sle_s    (pins_s[2]),
    .word_o   (word),
    .commit_o (commit)
  );

  slc_latches #(.FRAME_W(FRAME_W), .R_W(R_W), .A_W(A_W), .B_W(B_W)) u_lat (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit),
    .word_i    (word),
    .ref_div_o (ref_div_o),
    .a_cnt_o   (a_cnt_o),
    .b_cnt_o   (b_cnt_o),
    .func_o    (func_o),
    .cnt_rst_o (cnt_rst_o)
  );
endmodule

// File: tb/sim_serial_cfg_loader.sv
`timescale 1ns/1ps
module sim_serial_cfg_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk_i = 1'b0, ser_dat_i = 1'b0, ser_le_i = 1'b0;
  logic [13:0] ref_div_o;
  logic [5:0]  a_cnt_o;
  logic [12:0] b_cnt_o;
  logic [21:0] func_o;
  logic        cnt_rst_o;

  int checks = 0, failures = 0, pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_cfg_loader u0 (.clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk_i),
    .ser_dat_i(ser_dat_i), .ser_le_i(ser_le_i), .ref_div_o(ref_div_o),
    .a_cnt_o(a_cnt_o), .b_cnt_o(b_cnt_o), .func_o(func_o), .cnt_rst_o(cnt_rst_o));

  // behavioural model
  logic [23:0] m_sr = '0;
  logic [13:0] e_ref = '0, p_ref;
  logic [5:0]  e_a = '0, p_a;
  logic [12:0] e_b = '0, p_b;
  logic [21:0] e_fn = '0, p_fn;
  logic        e_pulse = 0, p_init;
  int pend = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    e_pulse = 0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        e_ref = p_ref; e_a = p_a; e_b = p_b; e_fn = p_fn; e_pulse = p_init;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 ref field", 32'(ref_div_o), 32'(e_ref));
      chk("R4 A field", 32'(a_cnt_o), 32'(e_a));
      chk("R4 B field", 32'(b_cnt_o), 32'(e_b));
      chk("R5 func field", 32'(func_o), 32'(e_fn));
      chk("R6 pulse", 32'(cnt_rst_o), 32'(e_pulse));
      if (cnt_rst_o) pulses++;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); ser_dat_i = b;
    wait_n(3); ser_clk_i = 1'b1; m_sr = {m_sr[22:0], b};
    wait_n(4); ser_clk_i = 1'b0;
    wait_n(3);
  endtask

  task automatic send_word(logic [23:0] w, int nbits);
    for (int i = nbits - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic strobe(int hold);
    @(negedge clk);
    ser_le_i = 1'b1;
    p_ref = e_ref; p_a = e_a; p_b = e_b; p_fn = e_fn; p_init = 0;
    case (m_sr[1:0])
      2'b00: p_ref = m_sr[15:2];
      2'b01: begin p_a = m_sr[7:2]; p_b = m_sr[20:8]; end
      2'b10: p_fn = m_sr[23:2];
      default: begin p_fn = m_sr[23:2]; p_init = 1; end
    endcase
    pend = 3;
    wait_n(hold); ser_le_i = 1'b0;
    wait_n(4);
  endtask

  initial begin
    wait_n(3);
    chk("R1 reset ref", 32'(ref_div_o), 0);
    chk("R1 reset pulse", 32'(cnt_rst_o), 0);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1 after release func", 32'(func_o), 0);

    // R3: reference write, junk in upper bits
    send_word({8'hC3, 14'h2A5B, 2'b00}, 24); strobe(6);
    chk("R3 ref loaded", 32'(ref_div_o), 32'h2A5B);
    chk("R3 A untouched", 32'(a_cnt_o), 0);

    // R4: counter write
    send_word({3'b101, 13'h1ABC, 6'h2D, 2'b01}, 24); strobe(6);
    chk("R4 A loaded", 32'(a_cnt_o), 32'h2D);
    chk("R4 B loaded", 32'(b_cnt_o), 32'h1ABC);
    chk("R4 ref kept", 32'(ref_div_o), 32'h2A5B);

    // R2/R5: function write, MSB-first placement
    pulses = 0;
    send_word({22'h2F0F0F, 2'b10}, 24); strobe(6);
    chk("R2 msb first func", 32'(func_o), 32'h2F0F0F);
    chk("R5 no pulse", 32'(pulses), 0);

    // R8: shifting without strobe changes nothing
    send_word(24'hFFFFFF, 24);
    chk("R8 no commit ref", 32'(ref_div_o), 32'h2A5B);
    chk("R8 no commit func", 32'(func_o), 32'h2F0F0F);

    // R8 latency: exact update edge
    send_word({14'h0, 8'h11, 2'b00}, 24);
    @(negedge clk); ser_le_i = 1'b1;
    p_ref = 14'h11; p_a = e_a; p_b = e_b; p_fn = e_fn; p_init = 0; pend = 3;
    wait_n(2);
    chk("R8 not yet after two edges", 32'(ref_div_o), 32'h2A5B);
    wait_n(1);
    chk("R8 updated on third edge", 32'(ref_div_o), 32'h11);
    wait_n(3); ser_le_i = 1'b0; wait_n(4);

    // R6 and R9: init write with a long strobe
    pulses = 0;
    send_word({22'h155555, 2'b11}, 24); strobe(40);
    chk("R6 init func", 32'(func_o), 32'h155555);
    chk("R9 one pulse on long strobe", 32'(pulses), 1);

    // R7: overlong frame, 3 leading bits discarded
    send_word(24'h7, 3);
    send_word({3'b000, 13'h0155, 6'h0A, 2'b01}, 24); strobe(6);
    chk("R7 last 24 bits A", 32'(a_cnt_o), 32'h0A);
    chk("R7 last 24 bits B", 32'(b_cnt_o), 32'h0155);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule